// File: doc/BRIEF.md
# Packed Dual 16-bit Integer ALU

This block is a SIMD integer ALU. It treats each 32-bit source word as two independent 16-bit lanes and applies one operation to both lanes in the same cycle. A 10-bit opcode selects the operation. Up to three sources feed it. Per source, one routing bit chooses which half of the word feeds the low result lane, and a second routing bit chooses which half feeds the high result lane. A clamp flag switches the arithmetic operations from wrapping to saturating.

The operations are multiply-add, low-half multiply, add, subtract, minimum, maximum, and three shifts. Each comes in a signed and an unsigned form where the two forms differ. The result is registered and appears one cycle after a valid input, together with an output valid flag. An opcode outside the map raises an illegal flag.

Top module: `pk16_alu`

## Requirements
- R1: Lane 0 of every word is bits 15:0 and lane 1 is bits 31:16. Both lanes run the same operation, and no carry, borrow or shifted-out bit passes between lanes.
- R2: The opcode values are:
  - 0x380: signed multiply-add
  - 0x381: multiply, keeping the low 16 bits
  - 0x382: signed add
  - 0x383: signed subtract
  - 0x384: shift left
  - 0x385: logical shift right
  - 0x386: arithmetic shift right
  - 0x387: signed max
  - 0x388: signed min
  - 0x389: unsigned multiply-add
  - 0x38A: unsigned add
  - 0x38B: unsigned subtract
  - 0x38C: unsigned max
  - 0x38D: unsigned min
- R3: Bit s of `selLo` and bit s of `selHi` route source s (0 = `srcA`, 1 = `srcB`, 2 = `srcC`). For the low result lane, `selLo[s]`=1 picks bits 31:16 of that source and 0 picks bits 15:0. `selHi[s]` picks the half for the high result lane in the same way.
- R4: Add computes a+b and subtract computes a−b, where a is from `srcA` and b is from `srcB`. With `clampEn`=0 these results wrap modulo 2^16.
- R5: With `clampEn`=1, add, subtract and multiply-add saturate each lane. The signed forms saturate to [−32768, 32767] and the unsigned forms to [0, 65535].
- R6: Multiply-add returns a*b+c per lane, with c taken from `srcC`. The result is the low 16 bits, or the saturated value when clamp is set.
- R7: The low multiply returns the low 16 bits of a*b. Clamp has no effect on it.
- R8: For the three shifts, the amount is the low 4 bits of the `srcA` lane and the value shifted is the `srcB` lane. The arithmetic shift right fills with the sign bit.
- R9: Min and max compare the lanes as two's-complement numbers in the signed forms and as unsigned numbers in the unsigned forms.
- R10: A valid input whose opcode is outside 0x380–0x38D sets `illegal` for one cycle and loads a zero result.
- R11: The result, `outValid` and `illegal` update one clock edge after the input is presented. `outValid` equals the previous cycle's `inValid`. With `inValid`=0 the result holds.
- R12: During reset, `result`, `outValid` and `illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input strobe |
| opcode | input | 10 | Operation code |
| srcA | input | 32 | Source 0 (shift amount for shifts) |
| srcB | input | 32 | Source 1 (shifted value for shifts) |
| srcC | input | 32 | Source 2 (addend for multiply-add) |
| selLo | input | 3 | Per-source half select for the low result lane |
| selHi | input | 3 | Per-source half select for the high result lane |
| clampEn | input | 1 | Saturate add, subtract and multiply-add |
| result | output | 32 | Registered packed result |
| outValid | output | 1 | Result valid |
| illegal | output | 1 | Unknown opcode seen on the last valid input |

## Verification
The lane-bound properties take for granted that straight routing is used: `selLo`=000 and `selHi`=111. Only under that routing can the unsigned max or the saturating unsigned add be compared against the raw source halves. The stimulus sweeps every opcode, both clamp settings and a set of edge lane values under that straight routing. It then exercises every routing combination separately, so that the routing corner cases are checked by the bench against its own arithmetic model.

// File: rtl/pk16_pkg.sv
package pk16_pkg;
  localparam int OPC_W = 10;

  localparam logic [OPC_W-1:0] OP_MAD_S = 10'h380;
  localparam logic [OPC_W-1:0] OP_MUL_LO = 10'h381;
  localparam logic [OPC_W-1:0] OP_ADD_S = 10'h382;
  localparam logic [OPC_W-1:0] OP_SUB_S = 10'h383;
  localparam logic [OPC_W-1:0] OP_SHL = 10'h384;
  localparam logic [OPC_W-1:0] OP_SHR = 10'h385;
  localparam logic [OPC_W-1:0] OP_ASR = 10'h386;
  localparam logic [OPC_W-1:0] OP_MAX_S = 10'h387;
  localparam logic [OPC_W-1:0] OP_MIN_S = 10'h388;
  localparam logic [OPC_W-1:0] OP_MAD_U = 10'h389;
  localparam logic [OPC_W-1:0] OP_ADD_U = 10'h38A;
  localparam logic [OPC_W-1:0] OP_SUB_U = 10'h38B;
  localparam logic [OPC_W-1:0] OP_MAX_U = 10'h38C;
  localparam logic [OPC_W-1:0] OP_MIN_U = 10'h38D;

  typedef enum logic [3:0] {
    K_NONE, K_MAD, K_MUL, K_ADD, K_SUB, K_SHL, K_SHR, K_ASR, K_MAX, K_MIN
  } kindT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic legal;
    kindT kind;
    logic sgn;
    logic sat;
  } ctrlT;
endpackage

// File: rtl/pk16_ctrl.sv
module pk16_ctrl
  import pk16_pkg::*;
(
  input  logic             inValid,
  input  logic [OPC_W-1:0] opcode,
  input  logic             clampEn,
  output ctrlT             ctrl
);
  kindT kind;
  logic sgn;
  logic legal;

  always_comb begin
    kind  = K_NONE;
    sgn   = 1'b0;
    legal = 1'b1;
    unique case (opcode)
      OP_MAD_S:  begin kind = K_MAD; sgn = 1'b1; end
      OP_MUL_LO: kind = K_MUL;
      OP_ADD_S:  begin kind = K_ADD; sgn = 1'b1; end
      OP_SUB_S:  begin kind = K_SUB; sgn = 1'b1; end
      OP_SHL:    kind = K_SHL;
      OP_SHR:    kind = K_SHR;
      OP_ASR:    kind = K_ASR;
      OP_MAX_S:  begin kind = K_MAX; sgn = 1'b1; end
      OP_MIN_S:  begin kind = K_MIN; sgn = 1'b1; end
      OP_MAD_U:  kind = K_MAD;
      OP_ADD_U:  kind = K_ADD;
      OP_SUB_U:  kind = K_SUB;
      OP_MAX_U:  kind = K_MAX;
      OP_MIN_U:  kind = K_MIN;
      default:   legal = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.load  = inValid;
    ctrl.legal = legal;
    ctrl.kind  = kind;
    ctrl.sgn   = sgn;
    ctrl.sat   = clampEn & ((kind == K_ADD) | (kind == K_SUB) | (kind == K_MAD));
  end
endmodule

// File: rtl/pk16_dp.sv
module pk16_dp
  import pk16_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlT                ctrl,
  input  logic [2*LANE_W-1:0] srcA,
  input  logic [2*LANE_W-1:0] srcB,
  input  logic [2*LANE_W-1:0] srcC,
  input  logic [2:0]          selLo,
  input  logic [2:0]          selHi,
  output logic [2*LANE_W-1:0] result,
  output logic                outValid,
  output logic                illegal
);
  localparam int LANES = 2;
  localparam int NSRC  = 3;
  localparam int DW    = LANES * LANE_W;
  localparam int WW    = 2 * LANE_W + 2;
  localparam int SH_W  = $clog2(LANE_W);

  localparam logic signed [WW-1:0] S_MAX = {{(WW-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
  localparam logic signed [WW-1:0] S_MIN = {{(WW-LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
  localparam logic signed [WW-1:0] U_MAX = {{(WW-LANE_W){1'b0}}, {LANE_W{1'b1}}};
  localparam logic signed [WW-1:0] U_MIN = '0;

  logic [DW-1:0]     src [NSRC];
  logic [LANE_W-1:0] opnd [LANES][NSRC];
  logic [LANE_W-1:0] laneOut [LANES];

  assign src[0] = srcA;
  assign src[1] = srcB;
  assign src[2] = srcC;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic pickHi;
      assign pickHi     = (l == 0) ? selLo[s] : selHi[s];
      assign opnd[l][s] = pickHi ? src[s][DW-1:LANE_W] : src[s][LANE_W-1:0];
    end

    logic [LANE_W-1:0]      a, b, c;
    logic signed [WW-1:0]   wa, wb, wc, wide;
    logic signed [WW-1:0]   hiLim, loLim;
    logic [SH_W-1:0]        amt;
    logic [LANE_W-1:0]      shOut, lres;

    assign a   = opnd[l][0];
    assign b   = opnd[l][1];
    assign c   = opnd[l][2];
    assign amt = a[SH_W-1:0];
    assign wa  = {{(WW-LANE_W){ctrl.sgn & a[LANE_W-1]}}, a};
    assign wb  = {{(WW-LANE_W){ctrl.sgn & b[LANE_W-1]}}, b};
    assign wc  = {{(WW-LANE_W){ctrl.sgn & c[LANE_W-1]}}, c};
    assign hiLim = ctrl.sgn ? S_MAX : U_MAX;
    assign loLim = ctrl.sgn ? S_MIN : U_MIN;

    always_comb begin
      unique case (ctrl.kind)
        K_MAD:   wide = wa * wb + wc;
        K_MUL:   wide = wa * wb;
        K_ADD:   wide = wa + wb;
        K_SUB:   wide = wa - wb;
        default: wide = '0;
      endcase
    end

    always_comb begin
      unique case (ctrl.kind)
        K_SHL:   shOut = b << amt;
        K_SHR:   shOut = b >> amt;
        K_ASR:   shOut = $signed(b) >>> amt;
        default: shOut = '0;
      endcase
    end

    always_comb begin
      unique case (ctrl.kind)
        K_SHL, K_SHR, K_ASR: lres = shOut;
        K_MAX:   lres = (wa > wb) ? a : b;
        K_MIN:   lres = (wa < wb) ? a : b;
        default: begin
          if (ctrl.sat && (wide > hiLim))      lres = hiLim[LANE_W-1:0];
          else if (ctrl.sat && (wide < loLim)) lres = loLim[LANE_W-1:0];
          else                                 lres = wide[LANE_W-1:0];
        end
      endcase
    end

    assign laneOut[l] = lres;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      outValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= ctrl.load;
      illegal  <= ctrl.load & ~ctrl.legal;
      if (ctrl.load) result <= ctrl.legal ? {laneOut[1], laneOut[0]} : '0;
    end
  end
endmodule

// File: rtl/pk16_alu.sv
module pk16_alu
  import pk16_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [OPC_W-1:0]    opcode,
  input  logic [2*LANE_W-1:0] srcA,
  input  logic [2*LANE_W-1:0] srcB,
  input  logic [2*LANE_W-1:0] srcC,
  input  logic [2:0]          selLo,
  input  logic [2:0]          selHi,
  input  logic                clampEn,
  output logic [2*LANE_W-1:0] result,
  output logic                outValid,
  output logic                illegal
);
  ctrlT ctrl;

  pk16_ctrl u_ctrl (
    .inValid (inValid),
    .opcode  (opcode),
    .clampEn (clampEn),
    .ctrl    (ctrl)
  );

  pk16_dp #(.LANE_W(LANE_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .srcA     (srcA),
    .srcB     (srcB),
    .srcC     (srcC),
    .selLo    (selLo),
    .selHi    (selHi),
    .result   (result),
    .outValid (outValid),
    .illegal  (illegal)
  );
endmodule

// File: rtl/pk16_chk.sv
module pk16_chk
  import pk16_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inValid,
  input logic [OPC_W-1:0]    opcode,
  input logic [2*LANE_W-1:0] srcA,
  input logic [2*LANE_W-1:0] srcB,
  input logic [2:0]          selLo,
  input logic [2:0]          selHi,
  input logic                clampEn,
  input logic [2*LANE_W-1:0] result,
  input logic                outValid,
  input logic                illegal
);
  localparam int DW = 2 * LANE_W;
  logic straight;
  assign straight = (selLo == 3'b000) && (selHi == 3'b111);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!outValid && $stable(result)));

  a_r10_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (outValid && (result == '0)));

  a_r2_mapped_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && (opcode >= OP_MAD_S) && (opcode <= OP_MIN_U)) |=> !illegal);

  a_r9_maxu_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && straight && (opcode == OP_MAX_U)) |=>
      ((result[LANE_W-1:0] >= $past(srcA[LANE_W-1:0])) &&
       (result[LANE_W-1:0] >= $past(srcB[LANE_W-1:0])) &&
       (result[DW-1:LANE_W] >= $past(srcA[DW-1:LANE_W]))));

  a_r5_addu_sat_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && straight && clampEn && (opcode == OP_ADD_U)) |=>
      ((result[LANE_W-1:0] >= $past(srcA[LANE_W-1:0])) &&
       (result[DW-1:LANE_W] >= $past(srcB[DW-1:LANE_W]))));
endmodule

bind pk16_alu pk16_chk #(.LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .opcode   (opcode),
  .srcA     (srcA),
  .srcB     (srcB),
  .selLo    (selLo),
  .selHi    (selHi),
  .clampEn  (clampEn),
  .result   (result),
  .outValid (outValid),
  .illegal  (illegal)
);

// File: tb/sim_pk16_alu.sv
`timescale 1ns/1ps
module sim_pk16_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [9:0]  opcode = '0;
  logic [31:0] srcA = '0, srcB = '0, srcC = '0;
  logic [2:0]  selLo = 3'b000, selHi = 3'b111;
  logic        clampEn = 1'b0;
  logic [31:0] result;
  logic        outValid, illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pk16_alu u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opcode(opcode),
    .srcA(srcA), .srcB(srcB), .srcC(srcC), .selLo(selLo), .selHi(selHi),
    .clampEn(clampEn), .result(result), .outValid(outValid), .illegal(illegal)
  );

  logic [15:0] edgeVal [8];
  initial begin
    edgeVal[0] = 16'h0000; edgeVal[1] = 16'h0001; edgeVal[2] = 16'h7FFF; edgeVal[3] = 16'h8000;
    edgeVal[4] = 16'hFFFF; edgeVal[5] = 16'h1234; edgeVal[6] = 16'h00F3; edgeVal[7] = 16'hC00F;
  end

  function automatic logic [15:0] model(logic [9:0] op, logic [15:0] a, logic [15:0] b,
                                        logic [15:0] c, bit cl);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint sc = longint'($signed(c));
    longint ua = longint'(a);
    longint ub = longint'(b);
    longint uc = longint'(c);
    longint r = 0;
    bit sSat = 0;
    bit uSat = 0;
    case (op)
      10'h380: begin r = sa * sb + sc; sSat = cl; end
      10'h381: r = ua * ub;
      10'h382: begin r = sa + sb; sSat = cl; end
      10'h383: begin r = sa - sb; sSat = cl; end
      10'h384: r = ub << a[3:0];
      10'h385: r = ub >> a[3:0];
      10'h386: r = sb >>> a[3:0];
      10'h387: r = (sa > sb) ? sa : sb;
      10'h388: r = (sa < sb) ? sa : sb;
      10'h389: begin r = ua * ub + uc; uSat = cl; end
      10'h38A: begin r = ua + ub; uSat = cl; end
      10'h38B: begin r = ua - ub; uSat = cl; end
      10'h38C: r = (ua > ub) ? ua : ub;
      10'h38D: r = (ua < ub) ? ua : ub;
      default: r = 0;
    endcase
    if (sSat) begin
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
    end
    if (uSat) begin
      if (r > 65535) r = 65535;
      if (r < 0) r = 0;
    end
    return r[15:0];
  endfunction

  function automatic logic [15:0] half(logic [31:0] w, bit hi);
    return hi ? w[31:16] : w[15:0];
  endfunction

  function automatic string tagOf(logic [9:0] op, bit cl);
    if (cl && (op == 10'h380 || op == 10'h389 || op == 10'h382 ||
               op == 10'h383 || op == 10'h38A || op == 10'h38B)) return "R5";
    case (op)
      10'h380, 10'h389: return "R6";
      10'h381: return "R7";
      10'h382, 10'h383, 10'h38A, 10'h38B: return "R4";
      10'h384, 10'h385, 10'h386: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] expR, bit expV, bit expI);
    checks++;
    if (result !== expR || outValid !== expV || illegal !== expI) begin
      errors++;
      $display("FAIL %s: result=%h valid=%b illegal=%b expected result=%h valid=%b illegal=%b",
               tag, result, outValid, illegal, expR, expV, expI);
    end
  endtask

  // present one operation at a negedge and check it at the following negedge
  task automatic run(logic [9:0] op, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                     logic [2:0] sl, logic [2:0] sh, bit cl, string tag);
    bit legal = (op >= 10'h380) && (op <= 10'h38D);
    logic [31:0] expR;
    expR[15:0]  = model(op, half(a, sl[0]), half(b, sl[1]), half(c, sl[2]), cl);
    expR[31:16] = model(op, half(a, sh[0]), half(b, sh[1]), half(c, sh[2]), cl);
    if (!legal) expR = '0;
    opcode = op; srcA = a; srcB = b; srcC = c;
    selLo = sl; selHi = sh; clampEn = cl; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(tag, expR, 1'b1, !legal);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    check("R12", 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4..R9: all opcodes, both clamp settings, edge lane values, straight routing
    for (int k = 0; k < 14; k++) begin
      for (int cl = 0; cl < 2; cl++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            logic [9:0] op = 10'h380 + 10'(k);
            run(op, {edgeVal[(i+5)%8], edgeVal[i]},
                    {edgeVal[(j+2)%8], edgeVal[j]},
                    {edgeVal[(i*3+j)%8], edgeVal[(i+j)%8]},
                3'b000, 3'b111, bit'(cl), tagOf(op, bit'(cl)));
          end
        end
      end
    end

    // R3: every routing combination
    for (int sl = 0; sl < 8; sl++) begin
      for (int sh = 0; sh < 8; sh++) begin
        run(10'h38A, 32'h1111_0022, 32'h0300_4000, 32'h0005_6000, 3'(sl), 3'(sh), 1'b0, "R3");
        run(10'h380, 32'hFFFE_0003, 32'h0007_8001, 32'h0100_FFF0, 3'(sl), 3'(sh), 1'b0, "R3");
      end
    end

    // R1: carry must not cross lanes
    run(10'h38A, 32'h0000_FFFF, 32'h0000_0001, 32'h0, 3'b000, 3'b111, 1'b0, "R1");
    run(10'h384, 32'h0004_0004, 32'h0000_F00F, 32'h0, 3'b000, 3'b111, 1'b0, "R1");

    // R10: unmapped opcodes
    run(10'h37F, 32'h1234_5678, 32'h1, 32'h2, 3'b000, 3'b111, 1'b0, "R10");
    run(10'h38E, 32'h1234_5678, 32'h1, 32'h2, 3'b000, 3'b111, 1'b1, "R10");
    run(10'h000, 32'hFFFF_FFFF, 32'h1, 32'h2, 3'b000, 3'b111, 1'b0, "R10");
    run(10'h3FF, 32'hFFFF_FFFF, 32'h1, 32'h2, 3'b000, 3'b111, 1'b0, "R10");

    // R11: output holds with no strobe
    run(10'h382, 32'h0010_0020, 32'h0001_0002, 32'h0, 3'b000, 3'b111, 1'b0, "R11");
    keep = result;
    opcode = 10'h38B; srcA = 32'hAAAA_5555; srcB = 32'h1234_4321; inValid = 1'b0;
    @(negedge clk);
    check("R11", keep, 1'b0, 1'b0);
    @(negedge clk);
    check("R11", keep, 1'b0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule